// File: doc/BRIEF.md
# Double-Word Exclusive Access Monitor

This block keeps the exclusive reservation of a single processor core and judges whether a 64-bit store-exclusive may complete. A load-exclusive reads a doubleword and arms the reservation. A later store-exclusive writes memory only while the reservation is still armed, and it reports a status code: 0 when it succeeds and 1 when it fails. Software uses this pair to build atomic read-modify-write loops. An interrupt handler can update the shared doubleword with a single store-exclusive that it does not retry. The interrupted code then sees its own store-exclusive fail, and it retries.

The reservation is one flag. It holds no address for matching a store. Any store-exclusive, to any address and with any outcome, drops the flag. A clear-exclusive also drops it. The block keeps the address of the last load-exclusive, but only to compare it against ordinary writes from other agents, which arrive on a snoop port. A snoop write to the reserved doubleword also drops the flag. A small backing memory, held as two banks of 32-bit words, makes the block testable on its own. Snoop writes update that memory.

Top module: `excl_monitor`

## Requirements
- R1: After reset the flag is clear, the outputs are zero and the memory holds zero, so the first store-exclusive returns status 1.
- R2: A load-exclusive to an aligned address returns the addressed doubleword on `rdata_o` with status 0 and arms the flag.
- R3: A store-exclusive that finds the flag armed, with no snoop write in the same cycle, writes its doubleword and returns status 0.
- R4: A store-exclusive that finds the flag clear returns status 1 and leaves memory unchanged.
- R5: Every store-exclusive drops the flag, so a second store-exclusive that follows it without a new load-exclusive fails.
- R6: The store-exclusive address is never compared with the reserved address. A store-exclusive to a different doubleword succeeds while the flag is armed.
- R7: When a second context issues a store-exclusive between a load-exclusive and its store-exclusive, the later store-exclusive fails and does not write.
- R8: A clear-exclusive drops the flag and returns status 0.
- R9: A snoop write to the reserved doubleword drops the flag and a snoop write to any other doubleword does not. A snoop write in the same cycle as a load-exclusive to that doubleword leaves the flag clear, and the load returns the value held before the snoop. Every snoop write updates memory.
- R10: When a snoop write and a store-exclusive occur in the same cycle, the store-exclusive returns status 1 and only the snoop data is written.
- R11: A load-exclusive issued while the flag is armed re-arms it and replaces the snooped address. A snoop write to the old address then no longer drops the flag.
- R12: `done_o` pulses high for one cycle in the cycle after each request strobe, and status, error and read data are valid in that cycle. With no request, `done_o` stays low.
- R13: Accesses must be 8-byte aligned, meaning address bits [2:0] are zero. A misaligned load-exclusive or store-exclusive raises `err_o` with status 1 and does not write memory. A misaligned load-exclusive leaves the flag as it was and returns zero data. A misaligned store-exclusive still drops the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ldx_i | input | 1 | Load-exclusive strobe |
| stx_i | input | 1 | Store-exclusive strobe |
| clx_i | input | 1 | Clear-exclusive strobe |
| addr_i | input | ADDR_W (7) | Byte address of the exclusive access |
| wdata_i | input | 64 | Store-exclusive data |
| snoop_we_i | input | 1 | Ordinary write by another agent |
| snoop_addr_i | input | ADDR_W (7) | Byte address of the snoop write |
| snoop_wdata_i | input | 64 | Snoop write data |
| rdata_o | output | 64 | Doubleword returned by a load-exclusive |
| status_o | output | 1 | 0 means success, 1 means failure |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned access |

## Verification
The assertions take for granted that at most one of the load, store and clear strobes is high in any cycle. They also take for granted that every strobe lasts exactly one cycle, and that the strobes are low while reset is asserted. The stimulus keeps to these rules: each table row drives at most one request, optionally alongside a snoop write, and the inputs return to idle before the next row. The rows that pair a snoop write with a request deliberately cover the same-cycle priority cases, which the input rules allow.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LDX  = 2'd1,
    OP_STX  = 2'd2,
    OP_CLX  = 2'd3
  } op_e;

  localparam logic ST_OK   = 1'b0;
  localparam logic ST_FAIL = 1'b1;
endpackage

// File: rtl/excl_flag.sv
module excl_flag #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [IDX_W-1:0] arm_idx_i,
  input  logic             drop_i,
  input  logic             snoop_we_i,
  input  logic [IDX_W-1:0] snoop_idx_i,
  output logic             armed_o
);
  logic             armed_q;
  logic [IDX_W-1:0] resv_idx_q;
  logic             snoop_hit;
  logic             arm_collide;

  // snooped address is kept for comparison only, never for store matching
  assign snoop_hit   = snoop_we_i && armed_q && (snoop_idx_i == resv_idx_q);
  assign arm_collide = snoop_we_i && (snoop_idx_i == arm_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      resv_idx_q <= '0;
    end else if (arm_i) begin
      armed_q    <= !arm_collide;
      resv_idx_q <= arm_idx_i;
    end else if (drop_i || snoop_hit) begin
      armed_q    <= 1'b0;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/excl_mem.sv
module excl_mem #(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32,
  parameter int LANES  = 2,
  localparam int DEPTH = 1 << IDX_W,
  localparam int DW_W  = WORD_W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW_W-1:0]  rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] bank_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
      end else if (we_i) begin
        bank_q[widx_i] <= wdata_i[g*WORD_W +: WORD_W];
      end
    end

    assign rdata_o[g*WORD_W +: WORD_W] = bank_q[ridx_i];
  end
endmodule

// File: rtl/excl_resp.sv
module excl_resp #(
  parameter int DW_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            status_i,
  input  logic            err_i,
  input  logic            load_i,
  input  logic [DW_W-1:0] rdata_i,
  output logic            done_o,
  output logic            status_o,
  output logic            err_o,
  output logic [DW_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      status_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      done_o <= fire_i;
      err_o  <= fire_i && err_i;
      if (fire_i) begin
        status_o <= status_i;
        rdata_o  <= load_i ? rdata_i : '0;
      end
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int IDX_W   = 4,
  parameter int WORD_W  = 32,
  parameter int LANES   = 2,
  localparam int DW_W   = WORD_W * LANES,
  localparam int OFS_W  = $clog2(DW_W / 8),
  localparam int ADDR_W = IDX_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldx_i,
  input  logic              stx_i,
  input  logic              clx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW_W-1:0]   wdata_i,
  input  logic              snoop_we_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic [DW_W-1:0]   snoop_wdata_i,
  output logic [DW_W-1:0]   rdata_o,
  output logic              status_o,
  output logic              done_o,
  output logic              err_o
);
  import excl_pkg::*;

  logic [IDX_W-1:0] req_idx, snp_idx, wr_idx;
  logic             misaligned, armed;
  logic             ldx_ok, stx_ok, mem_we, fail;
  logic [DW_W-1:0]  mem_rdata, wr_data;

  assign req_idx    = addr_i[OFS_W +: IDX_W];
  assign snp_idx    = snoop_addr_i[OFS_W +: IDX_W];
  assign misaligned = |addr_i[OFS_W-1:0];

  assign ldx_ok = ldx_i && !misaligned;
  // a snoop write in the same cycle wins over the store-exclusive
  assign stx_ok = stx_i && !misaligned && armed && !snoop_we_i;

  assign mem_we  = snoop_we_i || stx_ok;
  assign wr_idx  = snoop_we_i ? snp_idx : req_idx;
  assign wr_data = snoop_we_i ? snoop_wdata_i : wdata_i;

  assign fail = (ldx_i && misaligned) || (stx_i && !stx_ok) ? ST_FAIL : ST_OK;

  excl_flag #(.IDX_W(IDX_W)) u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (ldx_ok),
    .arm_idx_i   (req_idx),
    .drop_i      (stx_i || clx_i),
    .snoop_we_i  (snoop_we_i),
    .snoop_idx_i (snp_idx),
    .armed_o     (armed)
  );

  excl_mem #(.IDX_W(IDX_W), .WORD_W(WORD_W), .LANES(LANES)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .widx_i  (wr_idx),
    .wdata_i (wr_data),
    .ridx_i  (req_idx),
    .rdata_o (mem_rdata)
  );

  excl_resp #(.DW_W(DW_W)) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (ldx_i || stx_i || clx_i),
    .status_i (fail),
    .err_i    ((ldx_i || stx_i) && misaligned),
    .load_i   (ldx_ok),
    .rdata_i  (mem_rdata),
    .done_o   (done_o),
    .status_o (status_o),
    .err_o    (err_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ldx_i,
  input logic stx_i,
  input logic clx_i,
  input logic snoop_we_i,
  input logic status_o,
  input logic done_o,
  input logic err_o
);
  logic req;
  assign req = ldx_i || stx_i || clx_i;

  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ldx_i, stx_i, clx_i}) <= 1); // R12
  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> done_o); // R12
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> !done_o && !err_o); // R12
  AST_STX_PAIR_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i && $past(stx_i) |=> status_o); // R5
  AST_CLX_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clx_i |=> !status_o); // R8
  AST_SNOOP_BEATS_STX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i && snoop_we_i |=> status_o); // R10
  AST_ERR_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && status_o); // R13
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ldx_i      (ldx_i),
  .stx_i      (stx_i),
  .clx_i      (clx_i),
  .snoop_we_i (snoop_we_i),
  .status_o   (status_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
  localparam int AW = 7;
  localparam logic [1:0] I = 2'd0, L = 2'd1, S = 2'd2, C = 2'd3;
  localparam logic [63:0] DA = 64'h1111_2222_3333_4444, DB = 64'hBBBB_0000_BBBB_0001;
  localparam logic [63:0] DC = 64'hC0C0_C1C1_C2C2_C3C3, DD = 64'hDDDD_1234_5678_DDDD;
  localparam logic [63:0] DE = 64'hEEEE_EEEE_0000_0001, DF = 64'hF00D_F00D_F00D_F00D;
  localparam logic [63:0] DG = 64'h0606_0606_0606_0606, DH = 64'h8888_7777_6666_5555;
  localparam logic [63:0] DJ = 64'h0A0A_0B0B_0C0C_0D0D, DK = 64'hCAFE_0000_CAFE_1111;
  localparam logic [63:0] DL = 64'h1234_5678_9ABC_DEF0, DM = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] DN = 64'h0000_0000_FFFF_FFFF, DP = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] DQ = 64'h5A5A_5A5A_A5A5_A5A5, DR = 64'h0101_0101_0101_0101;

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [63:0] wd;
    logic        snp;
    logic [7:0]  saddr;
    logic [63:0] sd;
    logic        est;
    logic        eerr;
    logic        crd;
    logic [63:0] erd;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  S, 8'h08, DA, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R1
    '{4'd4,  L, 8'h08, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, '0}, // R4 R2
    '{4'd3,  S, 8'h08, DA, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R3
    '{4'd5,  S, 8'h08, DB, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R5
    '{4'd3,  L, 8'h08, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DA}, // R3
    '{4'd6,  S, 8'h10, DC, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R6
    '{4'd6,  L, 8'h10, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DC}, // R6
    '{4'd7,  S, 8'h18, DD, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R7
    '{4'd7,  S, 8'h10, DE, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R7
    '{4'd7,  L, 8'h10, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DC}, // R7
    '{4'd8,  C, 8'h00, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R8
    '{4'd8,  S, 8'h10, DE, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R8
    '{4'd2,  L, 8'h20, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, '0}, // R2
    '{4'd12, I, 8'h00, '0, 1'b1, 8'h20, DF, 1'b0, 1'b0, 1'b0, '0}, // R12
    '{4'd9,  S, 8'h20, DG, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R9
    '{4'd9,  L, 8'h20, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DF}, // R9
    '{4'd12, I, 8'h00, '0, 1'b1, 8'h28, DH, 1'b0, 1'b0, 1'b0, '0}, // R12
    '{4'd9,  S, 8'h20, DG, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R9
    '{4'd9,  L, 8'h28, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DH}, // R9
    '{4'd10, S, 8'h30, DJ, 1'b1, 8'h38, DK, 1'b1, 1'b0, 1'b0, '0}, // R10
    '{4'd10, L, 8'h30, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, '0}, // R10
    '{4'd10, L, 8'h38, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DK}, // R10
    '{4'd11, L, 8'h08, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DA}, // R11
    '{4'd12, I, 8'h00, '0, 1'b1, 8'h38, DL, 1'b0, 1'b0, 1'b0, '0}, // R12
    '{4'd11, S, 8'h08, DM, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R11
    '{4'd13, L, 8'h0C, '0, 1'b0, 8'h00, '0, 1'b1, 1'b1, 1'b1, '0}, // R13
    '{4'd11, L, 8'h08, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DM}, // R11
    '{4'd13, L, 8'h09, '0, 1'b0, 8'h00, '0, 1'b1, 1'b1, 1'b1, '0}, // R13
    '{4'd13, S, 8'h40, DN, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, '0}, // R13
    '{4'd2,  L, 8'h40, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DN}, // R2
    '{4'd13, S, 8'h44, DP, 1'b0, 8'h00, '0, 1'b1, 1'b1, 1'b0, '0}, // R13
    '{4'd13, S, 8'h40, DP, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R13
    '{4'd13, L, 8'h40, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DN}, // R13
    '{4'd9,  L, 8'h48, '0, 1'b1, 8'h48, DQ, 1'b0, 1'b0, 1'b1, '0}, // R9
    '{4'd9,  S, 8'h48, DR, 1'b0, 8'h00, '0, 1'b1, 1'b0, 1'b0, '0}, // R9
    '{4'd9,  L, 8'h48, '0, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b1, DQ}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ldx_i = 1'b0, stx_i = 1'b0, clx_i = 1'b0, snoop_we_i = 1'b0;
  logic [AW-1:0] addr_i = '0, snoop_addr_i = '0;
  logic [63:0]   wdata_i = '0, snoop_wdata_i = '0;
  logic [63:0]   rdata_o;
  logic          status_o, done_o, err_o;
  int            checks = 0, errors = 0;

  always #10 clk = ~clk;

  excl_monitor u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ldx_i(ldx_i), .stx_i(stx_i), .clx_i(clx_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .snoop_we_i(snoop_we_i),
    .snoop_addr_i(snoop_addr_i), .snoop_wdata_i(snoop_wdata_i),
    .rdata_o(rdata_o), .status_o(status_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [63:0] d,
                       input logic snp, input logic [7:0] sa, input logic [63:0] sd);
    ldx_i = (op == L); stx_i = (op == S); clx_i = (op == C);
    addr_i = a[AW-1:0]; wdata_i = d;
    snoop_we_i = snp; snoop_addr_i = sa[AW-1:0]; snoop_wdata_i = sd;
  endtask

  task automatic idle();
    drive(I, 8'h00, '0, 1'b0, 8'h00, '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", {63'd0, done_o}, 64'd0);
    chk("R1", "status", {63'd0, status_o}, 64'd0);
    chk("R1", "err", {63'd0, err_o}, 64'd0);
    chk("R1", "rdata", rdata_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v].rq);
      drive(VEC[v].op, VEC[v].addr, VEC[v].wd, VEC[v].snp, VEC[v].saddr, VEC[v].sd);
      @(negedge clk);
      chk("R12", $sformatf("vec%0d done", v), {63'd0, done_o}, {63'd0, VEC[v].op != I});
      if (VEC[v].op != I) begin
        chk(tag, $sformatf("vec%0d status", v), {63'd0, status_o}, {63'd0, VEC[v].est});
        chk(tag, $sformatf("vec%0d err", v), {63'd0, err_o}, {63'd0, VEC[v].eerr});
      end
      if (VEC[v].crd) chk(tag, $sformatf("vec%0d rdata", v), rdata_o, VEC[v].erd);
      idle();
    end

    // R12 done is a single pulse
    drive(C, 8'h00, '0, 1'b0, 8'h00, '0);
    @(negedge clk);
    idle();
    chk("R12", "pulse high", {63'd0, done_o}, 64'd1);
    @(negedge clk);
    chk("R12", "pulse low", {63'd0, done_o}, 64'd0);

    // R1 reset mid-run drops the flag and clears memory
    drive(L, 8'h08, '0, 1'b0, 8'h00, '0);
    @(negedge clk);
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "done in reset", {63'd0, done_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    drive(S, 8'h08, DB, 1'b0, 8'h00, '0);
    @(negedge clk);
    chk("R1", "stx after reset", {63'd0, status_o}, 64'd1);
    drive(L, 8'h08, '0, 1'b0, 8'h00, '0);
    @(negedge clk);
    chk("R1", "memory after reset", rdata_o, 64'd0);
    idle();
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule